// File: doc/BRIEF.md
# Pairwise-Vote Hamming Class Decoder

This block turns the outputs of a bank of pairwise binary classifiers into one class label per pixel. With K classes there are K(K-1)/2 classifiers, one per unordered pair of classes. Their decision bits arrive together as one vector. The block holds one code word per class. It XORs the decision vector with every code word, counts the differing bits to get a Hamming distance per class, and reports the class with the smallest distance together with that distance. The distance can serve as a confidence figure.

The datapath is fully pipelined and accepts a new vector on every clock. Results leave a fixed number of cycles later, in the order the vectors arrived. Reset loads the code words with the ideal pairwise pattern. A one-word write port can replace the code of any single class at run time, for example with a code taken from training.

Top module: `svm_hamming_decoder`

## Requirements
- R1: Decision bit for the pair (a, b) with a < b sits at index a*K - a*(a+1)/2 + (b-a-1). A 1 means the classifier favours class a and a 0 means it favours class b. For K=16 the pair (0,1) is bit 0, (1,2) is bit 15, (13,14) is bit 117 and (14,15) is bit 119.
- R2: After reset, the code word of class c has a 1 at every pair (c, b) with b > c and a 0 in every other position.
- R3: The distance of class c is the number of set bits in (decision vector XOR code word of c). Positions where a code word holds 0 as a don't-care still count when the decision bit there is 1.
- R4: out_label is the class with the smallest distance, and out_dist is that distance.
- R5: When two or more classes share the smallest distance, the lowest-numbered one is reported.
- R6: in_ready is always 1, so one vector is accepted on every clock. A vector accepted at one rising edge appears on the outputs after the (1+ceil(log2 K))-th rising edge. For K=16 that is 5 edges.
- R7: out_valid is 1 exactly in the cycles that correspond, at that latency, to accepted vectors. It is 0 for every cycle in which in_valid was 0.
- R8: When cfg_we is 1 at a rising edge, the code word of class cfg_class becomes cfg_code. A vector accepted at that same edge still uses the old code word. Vectors accepted at later edges use the new one.
- R9: While rst_n is 0, out_valid, out_label and out_dist are 0 and vectors already in flight are dropped. Reset also restores the R2 code words, discarding any earlier writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decision vector present |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_bits | input | K(K-1)/2 | Pairwise decision bits, laid out as in R1 |
| cfg_we | input | 1 | Write one class code word |
| cfg_class | input | ceil(log2 K) | Class whose code word is written |
| cfg_code | input | K(K-1)/2 | New code word |
| out_valid | output | 1 | Result present |
| out_label | output | ceil(log2 K) | Winning class |
| out_dist | output | ceil(log2(K(K-1)/2+1)) | Hamming distance of the winning class |

## Verification
The hardest case to reach from the ports is an exact tie between classes that sit in opposite halves of the comparison tree. Only a carefully built decision vector produces one. The stimulus uses a vector with seven of the fourteen class-1 positions set, which gives classes 1 and 15 equal distance. It also uses a rewritten class-3 code that equals the class-15 code. A further case writes a code word at the very edge a vector is accepted, to show that the old word is used for that vector, and then resets while a vector is in flight to show both that the vector is dropped and that the codes are restored.

// File: rtl/svm_hd_pkg.sv
package svm_hd_pkg;

   // Flat index of the decision bit for class pair (a, b), a < b
   function automatic int pair_pos(input int k, input int a, input int b);
      return a * k - (a * (a + 1)) / 2 + (b - a - 1);
   endfunction

   // Width able to hold a class index (at least one bit)
   function automatic int idx_width(input int k);
      return (k > 2) ? $clog2(k) : 1;
   endfunction

endpackage

// File: rtl/svm_hd_codes.sv
module svm_hd_codes #(
   parameter int K   = 16,
   parameter int NB  = K * (K - 1) / 2,
   parameter int CLW = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [CLW-1:0]         wsel,
   input  logic [NB-1:0]          wdata,
   output logic [K-1:0][NB-1:0]   codes_o
);
   import svm_hd_pkg::*;

   // Ideal pairwise pattern: ones where class c is the first of the pair
   function automatic logic [NB-1:0] ideal_code(input int c);
      logic [NB-1:0] w;
      w = '0;
      for (int b = c + 1; b < K; b++) w[pair_pos(K, c, b)] = 1'b1;
      return w;
   endfunction

   for (genvar c = 0; c < K; c++) begin : g_cls
      localparam logic [NB-1:0] INIT = ideal_code(c);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         codes_o[c] <= INIT;
         else if (we && wsel == CLW'(c))     codes_o[c] <= wdata;
      end
   end

endmodule

// File: rtl/svm_hd_dist.sv
module svm_hd_dist #(
   parameter int K  = 16,
   parameter int NB = K * (K - 1) / 2,
   parameter int DW = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   vld_i,
   input  logic [NB-1:0]          bits_i,
   input  logic [K-1:0][NB-1:0]   codes_i,
   output logic                   vld_o,
   output logic [K-1:0][DW-1:0]   dist_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_o <= 1'b0;
      else        vld_o <= vld_i;
   end

   for (genvar c = 0; c < K; c++) begin : g_cls
      logic [NB-1:0] diff;
      logic [DW-1:0] cnt;

      always_comb begin
         diff = bits_i ^ codes_i[c];
         cnt  = '0;
         for (int b = 0; b < NB; b++) cnt = cnt + DW'(diff[b]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     dist_o[c] <= '0;
         else if (vld_i) dist_o[c] <= cnt;
      end
   end

endmodule

// File: rtl/svm_hd_mintree.sv
module svm_hd_mintree #(
   parameter int K   = 16,
   parameter int CLW = 4,
   parameter int DW  = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   vld_i,
   input  logic [K-1:0][DW-1:0]   dist_i,
   output logic                   vld_o,
   output logic [CLW-1:0]         label_o,
   output logic [DW-1:0]          dist_o
);
   localparam int LVLS = $clog2(K);
   localparam int P    = 1 << LVLS;

   typedef struct packed {
      logic           live;
      logic [CLW-1:0] idx;
      logic [DW-1:0]  d;
   } node_t;

   logic [LVLS-1:0] vpipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[LVLS-2 >= 0 ? LVLS-2 : 0 : 0] & {(LVLS > 1 ? LVLS-1 : 1){LVLS > 1}}, vld_i} >> 0;
   end

   for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
      node_t lv [P >> l];

      if (l == 0) begin : g_leaf
         for (genvar n = 0; n < P; n++) begin : g_n
            if (n < K) begin : g_real
               assign lv[n] = '{live: 1'b1, idx: CLW'(n), d: dist_i[n]};
            end else begin : g_pad
               assign lv[n] = '0;
            end
         end
      end else begin : g_cmp
         for (genvar n = 0; n < (P >> l); n++) begin : g_n
            node_t a, b;
            assign a = g_lvl[l-1].lv[2*n];
            assign b = g_lvl[l-1].lv[2*n+1];
            // The right child wins only on a strictly smaller distance,
            // so the lower class index survives a tie.
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                lv[n] <= '0;
               else if (b.live && (!a.live || b.d < a.d)) lv[n] <= b;
               else                                       lv[n] <= a;
            end
         end
      end
   end

   assign vld_o   = vpipe[LVLS-1];
   assign label_o = g_lvl[LVLS].lv[0].idx;
   assign dist_o  = g_lvl[LVLS].lv[0].d;

endmodule

// File: rtl/svm_hamming_decoder.sv
module svm_hamming_decoder #(
   parameter  int NUM_CLASSES = 16,
   localparam int NB  = NUM_CLASSES * (NUM_CLASSES - 1) / 2,
   localparam int CLW = (NUM_CLASSES > 2) ? $clog2(NUM_CLASSES) : 1,
   localparam int DW  = $clog2(NB + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [NB-1:0]   in_bits,
   input  logic            cfg_we,
   input  logic [CLW-1:0]  cfg_class,
   input  logic [NB-1:0]   cfg_code,
   output logic            out_valid,
   output logic [CLW-1:0]  out_label,
   output logic [DW-1:0]   out_dist
);

   if (NUM_CLASSES < 2 || NUM_CLASSES > 64) begin : g_bad_k
      $error("NUM_CLASSES must lie between 2 and 64");
   end

   logic [NUM_CLASSES-1:0][NB-1:0] codes_q;
   logic [NUM_CLASSES-1:0][DW-1:0] dist_q;
   logic                           dist_vld;
   logic                           accept;

   assign in_ready = 1'b1;
   assign accept   = in_valid & in_ready;

   svm_hd_codes #(.K(NUM_CLASSES), .NB(NB), .CLW(CLW)) codes_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wsel    (cfg_class),
      .wdata   (cfg_code),
      .codes_o (codes_q)
   );

   svm_hd_dist #(.K(NUM_CLASSES), .NB(NB), .DW(DW)) dist_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (accept),
      .bits_i  (in_bits),
      .codes_i (codes_q),
      .vld_o   (dist_vld),
      .dist_o  (dist_q)
   );

   svm_hd_mintree #(.K(NUM_CLASSES), .CLW(CLW), .DW(DW)) tree_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (dist_vld),
      .dist_i  (dist_q),
      .vld_o   (out_valid),
      .label_o (out_label),
      .dist_o  (out_dist)
   );

endmodule

// File: rtl/svm_hamming_decoder_chk.sv
module svm_hamming_decoder_chk #(
   parameter  int K   = 16,
   localparam int NB  = K * (K - 1) / 2,
   localparam int CLW = (K > 2) ? $clog2(K) : 1,
   localparam int DW  = $clog2(NB + 1),
   localparam int LVLS = $clog2(K),
   localparam int LAT  = 1 + LVLS
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  out_valid,
   input logic [CLW-1:0]        out_label,
   input logic [DW-1:0]         out_dist,
   input logic [K-1:0][DW-1:0]  dist_q
);

   logic [LAT-1:0]  vsh;
   logic [CLW-1:0]  ref_lab_now;
   logic [DW-1:0]   ref_dst_now;
   logic [CLW-1:0]  ref_lab [LVLS];
   logic [DW-1:0]   ref_dst [LVLS];

   always_comb begin
      ref_lab_now = '0;
      ref_dst_now = dist_q[0];
      for (int c = 1; c < K; c++) begin
         if (dist_q[c] < ref_dst_now) begin
            ref_dst_now = dist_q[c];
            ref_lab_now = CLW'(c);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsh <= '0;
         for (int s = 0; s < LVLS; s++) begin
            ref_lab[s] <= '0;
            ref_dst[s] <= '0;
         end
      end else begin
         vsh        <= {vsh[LAT-2:0], in_valid};
         ref_lab[0] <= ref_lab_now;
         ref_dst[0] <= ref_dst_now;
         for (int s = 1; s < LVLS; s++) begin
            ref_lab[s] <= ref_lab[s-1];
            ref_dst[s] <= ref_dst[s-1];
         end
      end
   end

   // R6 R7
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vsh[LAT-1]);

   // R4
   dist_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_dist <= DW'(NB));

   // R4
   label_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> int'(out_label) < K);

   // R4 R5
   min_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_label == ref_lab[LVLS-1] && out_dist == ref_dst[LVLS-1]));

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_label == '0 && out_dist == '0));

endmodule

bind svm_hamming_decoder svm_hamming_decoder_chk #(.K(NUM_CLASSES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_label (out_label),
   .out_dist  (out_dist),
   .dist_q    (dist_q)
);

// File: tb/svm_hamming_decoder_tb_top.sv
`timescale 1ns/1ps
module svm_hamming_decoder_tb_top;
   localparam int K   = 16;
   localparam int NB  = 120;
   localparam int CLW = 4;
   localparam int DW  = 7;
   localparam int LAT = 1 + $clog2(K);
   localparam int NTV = 8;

   // Table: decision vector, expected label, expected distance
   localparam logic [NB-1:0] TV_BITS [NTV] = '{
      120'h0,                              // all pairs favour the later class
      {120{1'b1}},                         // all pairs favour the earlier class
      120'h7FFF,                           // class 0 row exact
      120'h1FFF_8000,                      // class 1 row exact
      120'(1) << 117,                      // tie 13 vs 15
      120'h3F_8000,                        // tie 1 vs 15 across tree halves
      120'h7FFF | (120'(1) << 119),        // class 0 plus a don't-care bit
      120'(1) << 119                       // class 14 row exact
   };
   localparam int TV_LAB [NTV] = '{15, 0, 0, 1, 13, 1, 0, 14};
   localparam int TV_DST [NTV] = '{0, 105, 0, 0, 1, 7, 1, 0};

   logic            clk = 1'b0;
   logic            rst_n;
   logic            in_valid;
   logic            in_ready;
   logic [NB-1:0]   in_bits;
   logic            cfg_we;
   logic [CLW-1:0]  cfg_class;
   logic [NB-1:0]   cfg_code;
   logic            out_valid;
   logic [CLW-1:0]  out_label;
   logic [DW-1:0]   out_dist;

   int n_chk  = 0;
   int n_err  = 0;
   bit done   = 1'b0;

   // Stream slots
   logic [NB-1:0] s_bits  [16];
   logic          s_vld   [16];
   logic          s_we    [16];
   int            s_wcls  [16];
   logic [NB-1:0] s_wcode [16];
   int            s_lab   [16];
   int            s_dst   [16];
   string         s_req   [16];

   always #4 clk = ~clk;

   svm_hamming_decoder #(.NUM_CLASSES(K)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_bits   (in_bits),
      .cfg_we    (cfg_we),
      .cfg_class (cfg_class),
      .cfg_code  (cfg_code),
      .out_valid (out_valid),
      .out_label (out_label),
      .out_dist  (out_dist)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic slot(input int k, input logic v, input logic [NB-1:0] bits,
                       input logic we, input int wcls, input logic [NB-1:0] wcode,
                       input int lab, input int dst, input string req);
      s_vld[k] = v;  s_bits[k] = bits; s_we[k] = we; s_wcls[k] = wcls;
      s_wcode[k] = wcode; s_lab[k] = lab; s_dst[k] = dst; s_req[k] = req;
   endtask

   // Called at a falling edge; drives one slot per cycle and checks each
   // result LAT rising edges after its acceptance.
   task automatic stream(input int n);
      fork
         begin
            for (int k = 0; k < n; k++) begin
               in_valid  = s_vld[k];
               in_bits   = s_bits[k];
               cfg_we    = s_we[k];
               cfg_class = CLW'(s_wcls[k]);
               cfg_code  = s_wcode[k];
               @(negedge clk);
            end
            in_valid = 1'b0;
            cfg_we   = 1'b0;
         end
         begin
            repeat (LAT) @(posedge clk);
            for (int k = 0; k < n; k++) begin
               @(negedge clk);
               chk(s_req[k], "out_valid", int'(out_valid), int'(s_vld[k]));
               chk("R6", "in_ready", int'(in_ready), 1);
               if (s_vld[k]) begin
                  chk(s_req[k], "out_label", int'(out_label), s_lab[k]);
                  chk(s_req[k], "out_dist", int'(out_dist), s_dst[k]);
               end
            end
         end
      join
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_bits = '0;
      cfg_we = 1'b0; cfg_class = '0; cfg_code = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9", "out_valid in reset", int'(out_valid), 0);
      chk("R9", "out_label in reset", int'(out_label), 0);
      chk("R9", "out_dist in reset", int'(out_dist), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk, back to back (R1 R2 R3 R4 R5 R6)
      for (int k = 0; k < NTV; k++)
         slot(k, 1'b1, TV_BITS[k], 1'b0, 0, '0, TV_LAB[k], TV_DST[k],
              (k == 4 || k == 5) ? "R5 tie" : "R1 R2 R3 R4 table");
      stream(NTV);
      @(negedge clk);
      chk("R7", "out_valid after drain", int'(out_valid), 0);

      // R8 write port, with a bubble for R7 and a cross-tree tie for R5
      slot(0, 1'b1, {NB{1'b1}}, 1'b1, 5, {NB{1'b1}}, 0, 105, "R8 same-edge old code");
      slot(1, 1'b0, '0,         1'b0, 0, '0,          0, 0,   "R7 bubble");
      slot(2, 1'b1, {NB{1'b1}}, 1'b0, 0, '0,          5, 0,   "R8 new code");
      slot(3, 1'b1, {NB{1'b1}}, 1'b1, 3, '0,          5, 0,   "R8 second write");
      slot(4, 1'b1, '0,         1'b0, 0, '0,          3, 0,   "R5 tie 3 vs 15");
      stream(5);

      // R9 reset with a vector in flight
      in_valid = 1'b1; in_bits = {NB{1'b1}};
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      for (int c = 0; c <= LAT; c++) begin
         @(negedge clk);
         chk("R9", "out_valid dropped", int'(out_valid), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      slot(0, 1'b1, {NB{1'b1}}, 1'b0, 0, '0, 0, 105, "R9 R2 codes restored");
      slot(1, 1'b1, '0,         1'b0, 0, '0, 15, 0,  "R9 R2 codes restored");
      stream(2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule